// File: doc/BRIEF.md
# Two-Sided Doorbell Register Set with Interrupt Masking

This block holds the doorbell state for both ends of a host-to-host bridge. Each end owns a 16-bit pending word and a 16-bit mask word. The far end rings bits into a pending word, either by writing that word's address on the register bus or by pulsing the matching bits of the peer-ring input. The owning end reads the pending word, clears bits with write-one-to-clear, and masks or unmasks bits through separate write-one addresses. Each end drives one interrupt line, and that line covers all of its doorbell bits.

The block has one 32-bit register bus and a small fixed offset map. For end 0, the pending, clear, set-mask and clear-mask operations sit at 0xC4C, 0xC50, 0xC54 and 0xC58. For end 1, they sit at 0xC5C, 0xC60, 0xC64 and 0xC68. A build-time parameter picks the interrupt style. Level style holds the line high while any unmasked bit is pending. Edge style gives a single-cycle pulse when the pending word leaves zero.

Edge style runs a two-state machine for each end:
- IRQ_EMPTY: the pending word is zero. The transition *arm-to-held* is taken when the word becomes non-zero, and it fires the pulse if an unmasked bit is pending.
- IRQ_HELD: the pending word is non-zero. It stays here while bits remain pending. The transition *held-to-empty* is taken when the word returns to zero.

Top module: `bridge_doorbell`

## Requirements
- R1: After reset, both pending words read 0, every mask bit is set, and both interrupt outputs are 0. A bit rung while still masked by the reset value raises no interrupt.
- R2: A bus write to an end's pending address (0xC4C for end 0, 0xC5C for end 1) ORs bits [15:0] of the write data into that pending word.
- R3: A one-cycle pulse on peer_ring bit s*16+k ORs bit k into end s's pending word.
- R4: A write to an end's clear address (0xC50 or 0xC60) clears the pending bits where the data holds a one. Zero bits leave the pending word unchanged.
- R5: A write to the set-mask address (0xC54 or 0xC64) masks the bits written as one. A write to the clear-mask address (0xC58 or 0xC68) unmasks them. Masking a pending bit drops its interrupt.
- R6: In level style, irq[s] equals the OR of (pending AND NOT mask) for end s, and it takes that value one clock after the registers change.
- R7: If a ring and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: Operations at one end's addresses, and ring bits for one end, leave the other end's pending word and interrupt unchanged.
- R9: In edge style, irq[s] is a one-cycle pulse, two clocks after a ring, whenever the pending word goes from zero to non-zero with an unmasked bit pending. Later rings and partial clears give no pulse. After the word returns to zero, the next ring pulses again.
- R10: While bus_rd is high at a pending address, bus_rdata returns that pending word in bits [15:0] with the upper bits zero. Any other address, or bus_rd low, gives 0. Write-data bits above 15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read enable |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| peer_ring | input | 32 | Ring strobes; bits [16s+15:16s] target end s |
| irq | output | 2 | Interrupt line for each end |

## Verification
The in-design properties assume that the bus presents at most one operation per cycle. They also assume that the set-mask and clear-mask strobes for an end never arrive together. The single address per cycle guarantees both of these conditions. The stimulus drives every write and ring pulse for exactly one clock, between falling edges. It reaches the ring-against-clear collision only by driving the peer-ring input in the same cycle as a bus clear. A level-style instance and an edge-style instance share all inputs, so the same sequence checks both interrupt styles.

// File: rtl/bdb_pkg.sv
package bdb_pkg;

    typedef enum logic [1:0] {
        OP_PEND  = 2'd0,
        OP_CLR   = 2'd1,
        OP_MSET  = 2'd2,
        OP_MCLR  = 2'd3
    } db_op_e;

    typedef enum logic {
        IRQ_EMPTY = 1'b0,
        IRQ_HELD  = 1'b1
    } irq_state_e;

    // Each end has a block of four word addresses, one per operation.
    function automatic logic [31:0] op_addr(input int side, input db_op_e op);
        logic [31:0] base;
        base = (side == 0) ? 32'h0000_0C4C : 32'h0000_0C5C;
        return base + {28'h0, op, 2'b00};
    endfunction

endpackage

// File: rtl/bdb_decode.sv
module bdb_decode
    import bdb_pkg::*;
#(
    parameter int NSIDES = 2,
    parameter int DB_W   = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                              wr_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    output logic [NSIDES-1:0][DB_W-1:0]       set_o,
    output logic [NSIDES-1:0][DB_W-1:0]       clr_o,
    output logic [NSIDES-1:0][DB_W-1:0]       mset_o,
    output logic [NSIDES-1:0][DB_W-1:0]       mclr_o
);
    logic [DB_W-1:0] bits;
    assign bits = wdata_i[DB_W-1:0];

    always_comb begin
        set_o  = '0;
        clr_o  = '0;
        mset_o = '0;
        mclr_o = '0;
        for (int s = 0; s < NSIDES; s++) begin
            if (wr_i) begin
                if (addr_i == ADDR_W'(op_addr(s, OP_PEND))) set_o[s]  = bits;
                if (addr_i == ADDR_W'(op_addr(s, OP_CLR)))  clr_o[s]  = bits;
                if (addr_i == ADDR_W'(op_addr(s, OP_MSET))) mset_o[s] = bits;
                if (addr_i == ADDR_W'(op_addr(s, OP_MCLR))) mclr_o[s] = bits;
            end
        end
    end
endmodule

// File: rtl/bdb_bank.sv
module bdb_bank #(
    parameter int DB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DB_W-1:0] set_i,
    input  logic [DB_W-1:0] clr_i,
    input  logic [DB_W-1:0] mset_i,
    input  logic [DB_W-1:0] mclr_i,
    output logic [DB_W-1:0] pend_o,
    output logic [DB_W-1:0] mask_o
);
    logic [DB_W-1:0] pend_q, mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '1;
        end else begin
            pend_q <= (pend_q & ~clr_i) | set_i;
            mask_q <= (mask_q | mset_i) & ~mclr_i;
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

    // R7
    ring_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

    // R5
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(mset_i & ~mclr_i)) |=> ((mask_q & $past(mset_i & ~mclr_i)) == $past(mset_i & ~mclr_i)));

    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|mclr_i) |=> ((mask_q & $past(mclr_i)) == '0));
endmodule

// File: rtl/bdb_irq.sv
module bdb_irq
    import bdb_pkg::*;
#(
    parameter int DB_W     = 16,
    parameter bit EDGE_IRQ = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DB_W-1:0] pend_i,
    input  logic [DB_W-1:0] mask_i,
    output logic            irq_o
);
    logic any_pend, any_live, irq_q;
    assign any_pend = |pend_i;
    assign any_live = |(pend_i & ~mask_i);
    assign irq_o    = irq_q;

    if (EDGE_IRQ) begin : g_edge
        irq_state_e state_q, state_n;
        logic       fire;

        always_ff @(posedge clk) begin
            if (!rst_n) state_q <= IRQ_EMPTY;
            else        state_q <= state_n;
        end

        always_comb begin
            state_n = state_q;
            fire    = 1'b0;
            unique case (state_q)
                IRQ_EMPTY: begin
                    if (any_pend) begin
                        state_n = IRQ_HELD;
                        fire    = any_live;
                    end
                end
                IRQ_HELD: begin
                    if (!any_pend) state_n = IRQ_EMPTY;
                end
                default: state_n = IRQ_EMPTY;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= fire;
        end

        // R9
        edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_q |=> !irq_q);
    end else begin : g_level
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= any_live;
        end

        // R6
        level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_q == $past(any_live));
    end
endmodule

// File: rtl/bridge_doorbell.sv
module bridge_doorbell
    import bdb_pkg::*;
#(
    parameter int DB_W     = 16,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter bit EDGE_IRQ = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [2*DB_W-1:0]    peer_ring,
    output logic [1:0]           irq
);
    localparam int NSIDES = 2;

    logic [NSIDES-1:0][DB_W-1:0] dec_set, dec_clr, dec_mset, dec_mclr;
    logic [NSIDES-1:0][DB_W-1:0] pend, mask;

    bdb_decode #(
        .NSIDES(NSIDES), .DB_W(DB_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_decode (
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .set_o   (dec_set),
        .clr_o   (dec_clr),
        .mset_o  (dec_mset),
        .mclr_o  (dec_mclr)
    );

    for (genvar s = 0; s < NSIDES; s++) begin : g_side
        logic [DB_W-1:0] set_all;
        assign set_all = dec_set[s] | peer_ring[s*DB_W +: DB_W];

        bdb_bank #(.DB_W(DB_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_all),
            .clr_i  (dec_clr[s]),
            .mset_i (dec_mset[s]),
            .mclr_i (dec_mclr[s]),
            .pend_o (pend[s]),
            .mask_o (mask[s])
        );

        bdb_irq #(.DB_W(DB_W), .EDGE_IRQ(EDGE_IRQ)) u_irq (
            .clk    (clk),
            .rst_n  (rst_n),
            .pend_i (pend[s]),
            .mask_i (mask[s]),
            .irq_o  (irq[s])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            for (int s = 0; s < NSIDES; s++) begin
                if (bus_addr == ADDR_W'(op_addr(s, OP_PEND))) bus_rdata = DATA_W'(pend[s]);
            end
        end
    end

    // R8
    side_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && (peer_ring[2*DB_W-1:DB_W] == '0)) |=> $stable(pend[1]));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq == 2'b00));
endmodule

// File: tb/bridge_doorbell_test.sv
`timescale 1ns/1ps
module bridge_doorbell_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] peer_ring = '0;
    logic [31:0] rdata_l, rdata_e;
    logic [1:0]  irq_l, irq_e;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bridge_doorbell #(.EDGE_IRQ(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_l),
        .peer_ring(peer_ring), .irq(irq_l)
    );

    bridge_doorbell #(.EDGE_IRQ(1'b1)) uut_edge (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_e),
        .peer_ring(peer_ring), .irq(irq_e)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic ring(input logic [31:0] v);
        @(negedge clk);
        peer_ring = v;
        @(negedge clk);
        peer_ring = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = rdata_l;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'hC4C, d); chk(d, 0, "R1 end0 pending after reset");
        rd(12'hC5C, d); chk(d, 0, "R1 end1 pending after reset");
        chk({30'd0, irq_l}, 0, "R1 level irq after reset");
        chk({30'd0, irq_e}, 0, "R1 edge irq after reset");
    endtask

    task automatic t_bus_ring();
        logic [31:0] d;
        wr(12'hC4C, 32'hFFFF_0005);
        rd(12'hC4C, d); chk(d, 32'h5, "R2 R10 bus ring end0, upper data ignored");
        rd(12'hC5C, d); chk(d, 0, "R8 end1 untouched by end0 ring");
        @(negedge clk);
        chk({31'd0, irq_l[0]}, 0, "R1 reset mask hides ring");
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(12'hC50, 32'h4);
        rd(12'hC4C, d); chk(d, 32'h1, "R4 clear one bit");
        wr(12'hC50, 32'h0);
        rd(12'hC4C, d); chk(d, 32'h1, "R4 zero clear has no effect");
        wr(12'hC50, 32'h1);
        rd(12'hC4C, d); chk(d, 32'h0, "R4 clear last bit");
    endtask

    task automatic t_level_mask();
        logic [31:0] d;
        wr(12'hC58, 32'h10);
        wr(12'hC4C, 32'h1);
        @(negedge clk);
        chk({31'd0, irq_l[0]}, 0, "R6 masked bit gives no irq");
        wr(12'hC4C, 32'h10);
        chk({31'd0, irq_l[0]}, 0, "R6 irq one cycle behind register");
        @(negedge clk);
        chk({31'd0, irq_l[0]}, 1, "R6 unmasked pending raises irq");
        wr(12'hC54, 32'h10);
        @(negedge clk);
        chk({31'd0, irq_l[0]}, 0, "R5 set mask drops irq");
        wr(12'hC50, 32'hFFFF);
        rd(12'hC4C, d); chk(d, 0, "R4 clear all end0");
    endtask

    task automatic t_peer_edge();
        logic [31:0] d;
        wr(12'hC68, 32'hFFFF);
        ring(32'h0100_0000);
        rd(12'hC5C, d); chk(d, 32'h100, "R3 peer_ring sets end1 bit 8");
        rd(12'hC4C, d); chk(d, 0, "R8 end0 untouched by end1 ring");
        chk({31'd0, irq_e[1]}, 0, "R9 edge pulse not yet");
        @(negedge clk);
        chk({31'd0, irq_l[1]}, 1, "R6 end1 level irq");
        chk({31'd0, irq_l[0]}, 0, "R8 end0 irq stays low");
        chk({31'd0, irq_e[1]}, 1, "R9 edge pulse on leaving zero");
        @(negedge clk);
        chk({31'd0, irq_e[1]}, 0, "R9 pulse lasts one cycle");
        ring(32'h0200_0000);
        @(negedge clk);
        chk({31'd0, irq_e[1]}, 0, "R9 no pulse on added bit");
        wr(12'hC60, 32'h100);
        @(negedge clk);
        chk({31'd0, irq_e[1]}, 0, "R9 no pulse on partial clear");
        rd(12'hC5C, d); chk(d, 32'h200, "R4 partial clear end1");
        wr(12'hC60, 32'hFFFF);
        @(negedge clk);
        chk({31'd0, irq_l[1]}, 0, "R6 level irq drops after clear");
        wr(12'hC5C, 32'h1);
        @(negedge clk);
        chk({31'd0, irq_e[1]}, 1, "R9 edge rearms after empty");
    endtask

    task automatic t_collision();
        logic [31:0] d;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'hC60; bus_wdata = 32'h5;
        peer_ring = 32'h0004_0000;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; peer_ring = '0;
        rd(12'hC5C, d); chk(d, 32'h4, "R7 ring beats clear");
    endtask

    task automatic t_read_map();
        logic [31:0] d;
        bus_addr = 12'hC5C; bus_rd = 1'b0;
        #1 chk(rdata_l, 0, "R10 no read gives zero");
        rd(12'h000, d); chk(d, 0, "R10 unmapped address reads zero");
        rd(12'hC60, d); chk(d, 0, "R10 clear address reads zero");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bus_ring();
        t_clear();
        t_level_mask();
        t_peer_edge();
        t_collision();
        t_read_map();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule